// File: doc/BRIEF.md
# Two-Wire Byte-Addressed Memory Target

This block is a target on a two-wire serial bus (I2C) that gives a controller access to an internal byte array. A fast system clock samples the bus clock and data lines, cleans them with a synchronizer and a short agreement filter, and finds START and STOP conditions. A transaction opens with a control byte that holds the four-bit device code 1010, three bits that must equal the strap pins, and a read/write flag. A write carries a two-byte word address followed by any number of data bytes. A read returns data from an internal pointer, one byte after another, for as long as the controller acknowledges.

The array holds 2^ADDR_W bytes. The deployed size is ADDR_W = 13 (8K bytes). The default of 10 keeps elaboration light. Writes take effect at once, with no busy period. A write-protect input blocks every store. A high-speed entry code is recognised and shown on a flag output until the next STOP. The data line is driven only low, through an output-enable.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset, sda_oe_o and hs_mode_o are 0 and the pointer is 0, so a current read taken straight after reset returns location 0. Array contents are kept across reset.
- R2: A control byte is accepted only when bits 7..4 are 1010 and bits 3..1 equal strap_i. If either field differs, the ninth clock is not acknowledged and SDA stays released until the next START.
- R3: A write control byte (bit 0 = 0) is followed by a high and a low address byte, then data. The target pulls SDA low on the ninth clock of every one of these bytes. Bits of the high address byte at position ADDR_W-8 and above are ignored.
- R4: The first data byte is stored at the loaded address and each later byte at the next address. After the top location 2^ADDR_W-1 the next address is 0.
- R5: A random read is a write control byte and two address bytes, then a repeated START and a read control byte (bit 0 = 1). Data then comes from the loaded address.
- R6: While the controller acknowledges (SDA low on the ninth clock), the next location is sent, wrapping from the top location to 0. After a not-acknowledge, SDA stays released until START or STOP.
- R7: A current read (a read control byte with no address) returns location n+1 when the last byte transferred was a read of n. It returns location n when the last byte transferred was a write to n.
- R8: While wp_i is 1, write transactions are still acknowledged, no location changes, and the pointer still advances as it would for a real store.
- R9: A first byte whose bits 7..3 are 00001 is not acknowledged and sets hs_mode_o. The flag stays set through repeated STARTs and normal transactions, and clears at STOP.
- R10: A START or STOP in the middle of a byte ends the transaction, and the partial byte is not stored.
- R11: Data bytes are sent MSB first, and SDA changes only while SCL is low. Bits from the controller are taken on SCL rising.
- R12: A pulse on SDA lasting fewer than FILT_LEN system clocks is ignored. A 2-clock low pulse while SCL is high neither ends nor corrupts a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Address strap pins matched against control bits 3..1 |
| wp_i | input | 1 | Write protect, 1 blocks all stores |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| hs_mode_o | output | 1 | High-speed entry code seen since the last STOP |

## Verification
Directed cases fix the values that tell the addressing paths apart. These are a current read just after reset, a current read after a write compared with one after a read, page writes and sequential reads across the top location, and a high address byte with its upper bits set. Further directed cases cover the control byte: a wrong strap value, a wrong device code, and the high-speed code. The bench also sends a START or STOP in the middle of a byte, writes with protection on, and injects a short SDA glitch, then reads back to confirm that nothing was stored. Random writes of 1 to 4 bytes at random addresses, each read back by either a random read or a current read, are compared with a byte model kept in the bench. This shows whether the pointer rule holds across mixed transaction orders.

// File: rtl/i2c_mem_target.sv
`timescale 1ns/1ps
module i2c_mem_target #(
  parameter int          ADDR_W   = 10,
  parameter int          FILT_LEN = 3,
  parameter logic [3:0]  DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o,
  output logic       hs_mode_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 8;

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_AHI, S_ALO, S_WR, S_RD, S_WAIT} st_t;

  logic [1:0]          scl_s, sda_s;
  logic [FILT_LEN-1:0] scl_w, sda_w;
  logic                scl_f, sda_f, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1;
      scl_w <= '1; sda_w <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1;
      scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_w <= {scl_w[FILT_LEN-2:0], scl_s[1]};
      sda_w <= {sda_w[FILT_LEN-2:0], sda_s[1]};
      if (&scl_w) scl_f <= 1'b1; else if (~|scl_w) scl_f <= 1'b0;
      if (&sda_w) sda_f <= 1'b1; else if (~|sda_w) sda_f <= 1'b0;
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  = scl_f & ~scl_p;
  assign scl_fall  = ~scl_f & scl_p;
  assign start_det = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_det  = scl_f & scl_p & ~sda_p & sda_f;

  st_t              state;
  logic [3:0]       cnt;
  logic [7:0]       sr, tx;
  logic [HI_W-1:0]  ahi;
  logic [ADDR_W-1:0] ptr, raddr, waddr;
  logic             inc_rd, wr_seq, go_rd, m_ack;
  logic             rd_act, busy, ctrl_hit, hs_code, next_rd;
  logic [7:0]       mem [DEPTH];
  logic [7:0]       rd_byte;
  logic             mem_we;

  assign rd_act   = (state == S_RD);
  assign busy     = (state != S_IDLE) && (state != S_WAIT);
  assign ctrl_hit = (sr[7:4] == DEV_CODE) && (sr[3:1] == strap_i);
  assign hs_code  = (sr[7:3] == 5'b00001);
  assign raddr    = inc_rd ? ptr + ADDR_W'(1) : ptr;
  assign waddr    = wr_seq ? ptr + ADDR_W'(1) : ptr;
  assign rd_byte  = mem[raddr];
  assign mem_we   = busy && (state == S_WR) && scl_fall && (cnt == 4'd8) && !wp_i;
  assign next_rd  = ((state == S_CTRL) && go_rd) || (rd_act && m_ack);

  always_ff @(posedge clk) begin
    if (mem_we) mem[waddr] <= sr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; sr <= '0; tx <= '0; ahi <= '0;
      ptr <= '0; inc_rd <= 1'b0; wr_seq <= 1'b0; go_rd <= 1'b0; m_ack <= 1'b0;
      sda_oe_o <= 1'b0; hs_mode_o <= 1'b0;
    end else if (start_det) begin
      state <= S_CTRL; cnt <= '0; sda_oe_o <= 1'b0;
    end else if (stop_det) begin
      state <= S_IDLE; cnt <= '0; sda_oe_o <= 1'b0; hs_mode_o <= 1'b0;
    end else if (busy) begin
      if (scl_rise) begin
        if (cnt < 4'd8) sr <= {sr[6:0], sda_f};
        if (cnt == 4'd8 && rd_act) m_ack <= ~sda_f;
        cnt <= cnt + 4'd1;
      end else if (scl_fall) begin
        if (cnt == 4'd8) begin
          case (state)
            S_CTRL: begin
              if (ctrl_hit) begin
                sda_oe_o <= 1'b1;
                go_rd    <= sr[0];
              end else begin
                state <= S_WAIT;
                if (hs_code) hs_mode_o <= 1'b1;
              end
            end
            S_AHI: begin
              sda_oe_o <= 1'b1;
              ahi      <= sr[HI_W-1:0];
            end
            S_ALO: begin
              sda_oe_o <= 1'b1;
              ptr      <= {ahi, sr};
              inc_rd   <= 1'b0;
              wr_seq   <= 1'b0;
            end
            S_WR: begin
              sda_oe_o <= 1'b1;
              ptr      <= waddr;
              wr_seq   <= 1'b1;
              inc_rd   <= 1'b0;
            end
            default: sda_oe_o <= 1'b0;
          endcase
        end else if (cnt == 4'd9) begin
          cnt <= '0;
          if (next_rd) begin
            state    <= S_RD;
            tx       <= rd_byte;
            sda_oe_o <= ~rd_byte[7];
            ptr      <= raddr;
            inc_rd   <= 1'b1;
          end else begin
            sda_oe_o <= 1'b0;
            case (state)
              S_CTRL:  state <= S_AHI;
              S_AHI:   state <= S_ALO;
              S_ALO:   state <= S_WR;
              S_WR:    state <= S_WR;
              default: state <= S_WAIT;
            endcase
          end
        end else if (rd_act && cnt != 4'd0) begin
          sda_oe_o <= ~tx[6];
          tx       <= {tx[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/i2c_mem_target_chk.sv
`timescale 1ns/1ps
module i2c_mem_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       start_det,
  input logic       stop_det,
  input logic       sda_oe,
  input logic       hs,
  input logic       rd_act,
  input logic [3:0] cnt
);
  p_oe_hold_scl_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(scl_f) |-> $stable(sda_oe));

  p_drive_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> ($past(cnt) >= 4'd8 || $past(rd_act)));

  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  p_start_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!sda_oe && cnt == 4'd0));

  p_hs_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !hs);

  p_hs_noack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs) |-> !sda_oe);

  p_cnt_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd9);
endmodule

bind i2c_mem_target i2c_mem_target_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe_o), .hs(hs_mode_o),
  .rd_act(rd_act), .cnt(cnt)
);

// File: tb/i2c_mem_target_tb_top.sv
`timescale 1ns/1ps
module i2c_mem_target_tb_top;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HALF   = 12;
  localparam int Q      = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, scl, msda, wp;
  logic [2:0] strap;
  logic       sda_oe, hs;
  wire        line = msda & ~sda_oe;

  i2c_mem_target #(.ADDR_W(ADDR_W), .FILT_LEN(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line), .strap_i(strap),
    .wp_i(wp), .sda_oe_o(sda_oe), .hs_mode_o(hs));

  int n_chk = 0, n_fail = 0, unstable = 0;
  logic [7:0]        model [DEPTH];
  logic [ADDR_W-1:0] mptr;
  bit                minc;
  logic [7:0]        wbuf [16];

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    msda = 1'b1; wait_n(HALF); scl = 1'b1; wait_n(HALF);
    msda = 1'b0; wait_n(HALF); scl = 1'b0; wait_n(Q);
  endtask

  task automatic bus_stop();
    msda = 1'b0; wait_n(HALF); scl = 1'b1; wait_n(HALF); msda = 1'b1; wait_n(HALF);
  endtask

  task automatic wbit(input logic b, input bit g, output logic s);
    logic s0;
    msda = b; wait_n(HALF - Q); scl = 1'b1;
    if (g) begin
      wait_n(4); msda = 1'b0; wait_n(2); msda = b; wait_n(HALF - 8); s0 = line; wait_n(2);
    end else begin
      wait_n(2); s0 = line; wait_n(HALF - 2);
    end
    s = line;
    if (!g && s0 !== s) unstable++;
    scl = 1'b0; wait_n(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, input int gbit, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) wbit(d[i], (i == gbit), s);
    wbit(1'b1, 1'b0, s);
    ack = ~s;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      wbit(1'b1, 1'b0, s);
      d[i] = s;
    end
    wbit(~mack, 1'b0, s);
  endtask

  function automatic logic [7:0] hi_byte(input logic [ADDR_W-1:0] a);
    logic [15:0] w;
    w = 16'(a);
    return w[15:8];
  endfunction

  task automatic addr_phase(input logic [ADDR_W-1:0] a, input logic [7:0] hi_extra, input string tag);
    logic ack;
    bus_start();
    wbyte({4'b1010, strap, 1'b0}, -1, ack); chk(8'(ack), 8'd1, {tag, " ctrl ack"});
    wbyte(hi_byte(a) | hi_extra, -1, ack);  chk(8'(ack), 8'd1, {tag, " addr hi ack"});
    wbyte(a[7:0], -1, ack);                 chk(8'(ack), 8'd1, {tag, " addr lo ack"});
  endtask

  task automatic write_txn(input logic [ADDR_W-1:0] a, input int n, input logic wpv,
                           input logic [7:0] hi_extra, input string tag);
    logic ack;
    logic [ADDR_W-1:0] p;
    wp = wpv;
    addr_phase(a, hi_extra, tag);
    p = a;
    for (int i = 0; i < n; i++) begin
      wbyte(wbuf[i], -1, ack); chk(8'(ack), 8'd1, {tag, " data ack"});
      if (!wpv) model[p] = wbuf[i];
      mptr = p; minc = 1'b0;
      p = p + ADDR_W'(1);
    end
    bus_stop();
    wp = 1'b0;
  endtask

  task automatic read_bytes(input logic [ADDR_W-1:0] first, input int n, input string tag);
    logic [7:0] d;
    logic [ADDR_W-1:0] p;
    int u0;
    u0 = unstable;
    p = first;
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, d);
      chk(d, model[p], tag);
      mptr = p; minc = 1'b1;
      p = p + ADDR_W'(1);
    end
    chk(8'(unstable - u0), 8'd0, "R11 SDA stable while SCL high");
  endtask

  task automatic rand_read(input logic [ADDR_W-1:0] a, input int n, input string tag);
    logic ack;
    addr_phase(a, 8'h00, tag);
    bus_start();
    wbyte({4'b1010, strap, 1'b1}, -1, ack); chk(8'(ack), 8'd1, {tag, " read ctrl ack"});
    read_bytes(a, n, tag);
    bus_stop();
  endtask

  task automatic cur_read(input int n, input string tag);
    logic ack;
    logic [ADDR_W-1:0] f;
    f = minc ? mptr + ADDR_W'(1) : mptr;
    bus_start();
    wbyte({4'b1010, strap, 1'b1}, -1, ack); chk(8'(ack), 8'd1, {tag, " ctrl ack"});
    read_bytes(f, n, tag);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic ack, s;
    logic [7:0] d;
    int seed;
    rst_n = 1'b0; scl = 1'b1; msda = 1'b1; wp = 1'b0; strap = 3'b101;
    mptr = '0; minc = 1'b0;
    seed = $urandom(32'd20240611);
    wait_n(6);
    chk(8'(sda_oe), 8'd0, "R1 sda released in reset");
    rst_n = 1'b1;
    wait_n(10);
    chk(8'(sda_oe), 8'd0, "R1 sda released after reset");
    chk(8'(hs), 8'd0, "R1 hs flag clear after reset");

    wbuf[0] = 8'h3C; wbuf[1] = 8'h5A; wbuf[2] = 8'h99; wbuf[3] = 8'h01;
    write_txn(10'h000, 4, 1'b0, 8'h00, "R4 page write");
    rst_n = 1'b0; wait_n(4); rst_n = 1'b1; wait_n(10);
    mptr = '0; minc = 1'b0;
    cur_read(1, "R1 current read after reset");
    cur_read(1, "R7 current read after read");

    bus_start();
    wbyte({4'b1010, 3'b010, 1'b0}, -1, ack); chk(8'(ack), 8'd0, "R2 strap mismatch no ack");
    wbyte(8'hFF, -1, ack);                   chk(8'(ack), 8'd0, "R2 released after mismatch");
    bus_stop();
    bus_start();
    wbyte({4'b1011, strap, 1'b0}, -1, ack);  chk(8'(ack), 8'd0, "R2 device code mismatch no ack");
    bus_stop();

    wbuf[0] = 8'hC7;
    write_txn(10'h110, 1, 1'b0, 8'hFC, "R3 byte write");
    cur_read(1, "R7 current read after write");
    rand_read(10'h110, 1, "R5 random read");
    rand_read(10'h000, 3, "R6 sequential read");

    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    write_txn(10'h3FE, 4, 1'b0, 8'h00, "R4 page write wrap");
    rand_read(10'h3FF, 3, "R6 sequential read wrap");
    rand_read(10'h000, 2, "R4 wrapped bytes at 0");

    addr_phase(10'h3FE, 8'h00, "R6 nack");
    bus_start();
    wbyte({4'b1010, strap, 1'b1}, -1, ack);
    rbyte(1'b0, d); chk(d, model[10'h3FE], "R6 byte before nack");
    wbit(1'b1, 1'b0, s); chk(8'(s), 8'd1, "R6 released after nack");
    bus_stop();
    mptr = 10'h3FE; minc = 1'b1;

    wbuf[0] = 8'hEE; wbuf[1] = 8'hDD;
    write_txn(10'h001, 2, 1'b1, 8'h00, "R8 protected write");
    rand_read(10'h001, 2, "R8 protected data kept");
    cur_read(1, "R8 pointer advanced under protect");

    bus_start();
    wbyte(8'h0D, -1, ack); chk(8'(ack), 8'd0, "R9 hs code not acked");
    chk(8'(hs), 8'd1, "R9 hs flag set");
    bus_start();
    wbyte({4'b1010, strap, 1'b1}, -1, ack); chk(8'(ack), 8'd1, "R9 ctrl after hs ack");
    read_bytes(minc ? mptr + ADDR_W'(1) : mptr, 1, "R9 read after hs");
    chk(8'(hs), 8'd1, "R9 hs flag held until stop");
    bus_stop();
    chk(8'(hs), 8'd0, "R9 hs flag cleared by stop");

    addr_phase(10'h110, 8'h00, "R10 abort");
    for (int i = 0; i < 4; i++) wbit(1'b0, 1'b0, s);
    bus_start();
    wbyte({4'b1010, strap, 1'b0}, -1, ack); chk(8'(ack), 8'd1, "R10 ctrl after abort start");
    bus_stop();
    addr_phase(10'h111, 8'h00, "R10 stop abort");
    for (int i = 0; i < 5; i++) wbit(1'b1, 1'b0, s);
    bus_stop();
    mptr = 10'h111; minc = 1'b0;
    rand_read(10'h110, 1, "R10 aborted byte not stored");

    addr_phase(10'h222, 8'h00, "R12 glitch");
    wbyte(8'hA5, 7, ack); chk(8'(ack), 8'd1, "R12 ack despite glitch");
    model[10'h222] = 8'hA5; mptr = 10'h222; minc = 1'b0;
    bus_stop();
    rand_read(10'h222, 1, "R12 glitched byte stored intact");

    for (int k = 0; k < 14; k++) begin
      logic [ADDR_W-1:0] a;
      int n;
      a = ADDR_W'($urandom);
      n = 1 + int'($urandom % 4);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      write_txn(a, n, 1'b0, 8'h00, "R4 random write");
      if ($urandom % 2 == 0) rand_read(a, n, "R5 random readback");
      else                   cur_read(1, "R7 random current read");
    end

    report();
    $finish;
  end
endmodule